// File: doc/BRIEF.md
# Timer Compare-Match Unit

This block watches a free-running 16-bit timer that lives outside it and compares the timer against a 16-bit compare register of its own on every clock cycle. When the two become equal, the block acts according to a 4-bit mode field. It can drive its output pin high, drive it low, or leave the pin alone and only raise an interrupt flag. In a fourth mode it sends a one-cycle pulse that clears the external timer. In the same mode it can also send a one-cycle pulse that asks an external converter to start a conversion, if the converter is enabled.

An equality that lasts several cycles counts as one match episode and causes exactly one action. The interrupt flag is sticky and stays set until software clears it. When the mode first switches to set-on-match or clear-on-match, the pin is preset to the level opposite to the one the match will drive. A later match then always shows up as an edge on the pin. Every output is registered. The result of a matching cycle appears right after the clock edge that ends that cycle.

Top module: `cmp_event_unit`

## Requirements
- R1: A write to the compare register applies from the cycle after the write. A match needs all 16 bits of the timer to equal the compare register, so a timer value that differs in any single bit causes no match. After reset the compare register holds 0.
- R2: In mode 4'b1000, a match drives the pin to 1.
- R3: In mode 4'b1001, a match drives the pin to 0.
- R4: In mode 4'b1010, a match sets the flag and leaves the pin unchanged.
- R5: In each of the modes 4'b1000 to 4'b1011, a match sets the flag. The flag then stays at 1 until flag_clr is asserted. If a match and flag_clr occur in the same cycle, the flag stays set.
- R6: A run of consecutive matching cycles is one episode and causes a single action and a single flag set. A flag cleared during the run stays clear. A new episode needs at least one cycle without a match.
- R7: When the mode changes to 4'b1000, the pin is preset to 0. When the mode changes to 4'b1001, the pin is preset to 1. If a match happens in the same cycle as the mode change, the match action wins.
- R8: In mode 4'b1011, a match produces a one-cycle pulse on tmr_rst and leaves the pin unchanged. tmr_rst pulses in no other mode.
- R9: conv_start pulses together with tmr_rst only when conv_en is 1 in the matching cycle and the HAS_CONV parameter is 1. Otherwise conv_start stays 0.
- R10: Mode codes outside 4'b1000 to 4'b1011 cause no pin change, no flag set and no pulses, even when the timer matches.
- R11: While rst is asserted and right after it is released, pin_out, flag_out, tmr_rst and conv_start are all 0.
- R12: Each output reflects the inputs of a matching cycle only after the clock edge that closes that cycle, never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_val | input | 16 | Current value of the external timer |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_data | input | 16 | Compare register write value |
| mode | input | 4 | Match mode select |
| flag_clr | input | 1 | Clears the interrupt flag |
| conv_en | input | 1 | Converter enabled |
| pin_out | output | 1 | Compare output pin |
| flag_out | output | 1 | Sticky interrupt flag |
| tmr_rst | output | 1 | One-cycle pulse that clears the external timer |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |

## Verification
The bench sweeps all sixteen mode codes and every single-bit miss around a compare value. It checks every output against a model that it builds from the requirements.

Each corner case targets a specific wrong design:
- Timer held at the matching value. A design without episode detection would fire again every cycle, re-raise a cleared flag and send repeated timer-reset pulses.
- Mode change, and a mode change coinciding with a match. A design that skipped the preset, or let the preset win over the match, would leave the pin at the wrong level.
- Flag clear in the same cycle as a match. A wrong design would lose the interrupt.
- Converter enable low and high in trigger mode. A wrong design would start conversions while the converter is off.
- Invalid mode codes. A wrong design would still flag matches in those modes.

// File: rtl/cmp_event_pkg.sv
package cmp_event_pkg;

    localparam int unsigned MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 4'b0000,
        MODE_SET  = 4'b1000,
        MODE_CLR  = 4'b1001,
        MODE_FLAG = 4'b1010,
        MODE_TRIG = 4'b1011
    } cmp_mode_e;

    // Decoded per-mode behaviour
    typedef struct packed {
        logic active;   // one of the four compare modes
        logic drive_hi;
        logic drive_lo;
        logic trig;
    } cmp_act_t;

    // Comparator result
    typedef struct packed {
        logic hit;      // equality this cycle
        logic first;    // first cycle of an equality episode
    } cmp_hit_t;

    function automatic cmp_act_t decode_mode(logic [MODE_W-1:0] code);
        cmp_act_t a;
        a.active   = (code[MODE_W-1:2] == 2'b10);
        a.drive_hi = (code == MODE_SET);
        a.drive_lo = (code == MODE_CLR);
        a.trig     = (code == MODE_TRIG);
        return a;
    endfunction

endpackage

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tmr_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output cmp_event_pkg::cmp_hit_t hit_o
);
    logic [W-1:0] cmp_q;
    logic         hit_prev;
    logic         hit_now;

    assign hit_now     = (tmr_val == cmp_q);
    assign hit_o.hit   = hit_now;
    assign hit_o.first = hit_now & ~hit_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q    <= '0;
            hit_prev <= 1'b0;
        end else begin
            if (wr_en) cmp_q <= wr_data;
            hit_prev <= hit_now;
        end
    end
endmodule

// File: rtl/cmp_mode_ctl.sv
module cmp_mode_ctl
    import cmp_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    output cmp_act_t          act_o,
    output logic              preset_hi,
    output logic              preset_lo
);
    logic [MODE_W-1:0] mode_q;
    logic              entering;

    assign act_o     = decode_mode(mode);
    assign entering  = (mode != mode_q);
    assign preset_lo = entering & act_o.drive_hi;
    assign preset_hi = entering & act_o.drive_lo;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_OFF;
        else     mode_q <= mode;
    end
endmodule

// File: rtl/cmp_out_stage.sv
module cmp_out_stage
    import cmp_event_pkg::*;
#(
    parameter bit HAS_CONV = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  cmp_act_t act,
    input  logic     first,
    input  logic     preset_hi,
    input  logic     preset_lo,
    input  logic     flag_clr,
    input  logic     conv_en,
    output logic     pin_q,
    output logic     flag_q,
    output logic     trig_q,
    output logic     conv_q
);
    logic fire;
    logic pin_d;
    logic flag_d;
    logic trig_d;
    logic conv_d;

    assign fire = act.active & first;

    always_comb begin
        pin_d = pin_q;
        if (preset_hi) pin_d = 1'b1;
        if (preset_lo) pin_d = 1'b0;
        if (fire && act.drive_hi) pin_d = 1'b1;
        if (fire && act.drive_lo) pin_d = 1'b0;
    end

    always_comb begin
        flag_d = flag_q;
        if (flag_clr) flag_d = 1'b0;
        if (fire)     flag_d = 1'b1;
    end

    assign trig_d = fire & act.trig;

    generate
        if (HAS_CONV) begin : g_conv
            assign conv_d = trig_d & conv_en;
        end else begin : g_noconv
            assign conv_d = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            flag_q <= 1'b0;
            trig_q <= 1'b0;
            conv_q <= 1'b0;
        end else begin
            pin_q  <= pin_d;
            flag_q <= flag_d;
            trig_q <= trig_d;
            conv_q <= conv_d;
        end
    end
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
    import cmp_event_pkg::*;
#(
    parameter int unsigned W        = 16,
    parameter bit          HAS_CONV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      tmr_val,
    input  logic              cmp_wr_en,
    input  logic [W-1:0]      cmp_wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_clr,
    input  logic              conv_en,
    output logic              pin_out,
    output logic              flag_out,
    output logic              tmr_rst,
    output logic              conv_start
);
    cmp_hit_t hit;
    cmp_act_t act;
    logic     preset_hi;
    logic     preset_lo;

    cmp_match_det #(.W(W)) u_det (
        .clk     (clk),
        .rst     (rst),
        .tmr_val (tmr_val),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .hit_o   (hit)
    );

    cmp_mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .act_o     (act),
        .preset_hi (preset_hi),
        .preset_lo (preset_lo)
    );

    cmp_out_stage #(.HAS_CONV(HAS_CONV)) u_out (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .first     (hit.first),
        .preset_hi (preset_hi),
        .preset_lo (preset_lo),
        .flag_clr  (flag_clr),
        .conv_en   (conv_en),
        .pin_q     (pin_out),
        .flag_q    (flag_out),
        .trig_q    (tmr_rst),
        .conv_q    (conv_start)
    );
endmodule

// File: rtl/cmp_event_chk.sv
module cmp_event_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] mode,
    input logic       flag_clr,
    input logic       conv_en,
    input logic       pin_out,
    input logic       flag_out,
    input logic       tmr_rst,
    input logic       conv_start
);
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_out && !flag_clr) |=> flag_out);

    a_r8_trig_single: assert property (@(posedge clk) disable iff (rst)
        tmr_rst |=> !tmr_rst);

    a_r8_trig_mode: assert property (@(posedge clk) disable iff (rst)
        tmr_rst |-> ($past(mode) == 4'b1011));

    a_r9_conv_needs_trig: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (tmr_rst && $past(conv_en)));

    a_r2_set_no_fall: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(mode) == 4'b1000
         && $past(mode, 2) == 4'b1000) |-> !$fell(pin_out));

    a_r3_clr_no_rise: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(mode) == 4'b1001
         && $past(mode, 2) == 4'b1001) |-> !$rose(pin_out));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ($past(mode[3:2]) != 2'b10) |-> (!tmr_rst && !$rose(flag_out)));
endmodule

bind cmp_event_unit cmp_event_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .flag_clr   (flag_clr),
    .conv_en    (conv_en),
    .pin_out    (pin_out),
    .flag_out   (flag_out),
    .tmr_rst    (tmr_rst),
    .conv_start (conv_start)
);

// File: tb/test_cmp_event_unit.sv
module test_cmp_event_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] tmr_val;
    logic         cmp_wr_en;
    logic [W-1:0] cmp_wr_data;
    logic [3:0]   mode;
    logic         flag_clr;
    logic         conv_en;
    logic         pin_out, flag_out, tmr_rst, conv_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // requirement-level model state
    logic [W-1:0] m_cmp;
    logic         m_prev, m_pin, m_flag, m_trig, m_conv;
    logic [3:0]   m_mode;

    always #10 clk = ~clk;

    cmp_event_unit #(.W(W), .HAS_CONV(1'b1)) i_cmp_event_unit (
        .clk(clk), .rst(rst), .tmr_val(tmr_val), .cmp_wr_en(cmp_wr_en),
        .cmp_wr_data(cmp_wr_data), .mode(mode), .flag_clr(flag_clr),
        .conv_en(conv_en), .pin_out(pin_out), .flag_out(flag_out),
        .tmr_rst(tmr_rst), .conv_start(conv_start)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // One clock cycle: predict from requirements, advance, compare all outputs
    task automatic cyc(string req);
        logic hit, first, act, enter;
        hit   = (tmr_val == m_cmp);
        first = hit && !m_prev;
        act   = (mode[3:2] == 2'b10) && first;
        enter = (mode != m_mode);
        if (enter && mode == 4'b1000) m_pin = 1'b0;
        if (enter && mode == 4'b1001) m_pin = 1'b1;
        if (act && mode == 4'b1000)   m_pin = 1'b1;
        if (act && mode == 4'b1001)   m_pin = 1'b0;
        if (flag_clr) m_flag = 1'b0;
        if (act)      m_flag = 1'b1;
        m_trig = act && mode == 4'b1011;
        m_conv = m_trig && conv_en;
        if (cmp_wr_en) m_cmp = cmp_wr_data;
        m_prev = hit;
        m_mode = mode;
        @(posedge clk); #1;
        cmp_wr_en = 1'b0;
        flag_clr  = 1'b0;
        check({req, " pin"},  pin_out,    m_pin);
        check({req, " flag"}, flag_out,   m_flag);
        check({req, " trig"}, tmr_rst,    m_trig);
        check({req, " conv"}, conv_start, m_conv);
    endtask

    task automatic do_reset();
        rst = 1'b1; tmr_val = '0; cmp_wr_en = 1'b0; cmp_wr_data = '0;
        mode = 4'b0000; flag_clr = 1'b0; conv_en = 1'b0;
        @(posedge clk); #1;
        check("R11 pin in reset", pin_out, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        m_cmp = '0; m_prev = 0; m_pin = 0; m_flag = 0; m_trig = 0; m_conv = 0;
        m_mode = 4'b0000;
        check("R11 pin",  pin_out, 0);
        check("R11 flag", flag_out, 0);
        check("R11 trig", tmr_rst, 0);
        check("R11 conv", conv_start, 0);
    endtask

    task automatic write_cmp(logic [W-1:0] v);
        cmp_wr_en = 1'b1; cmp_wr_data = v;
        cyc("R1 write");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        do_reset();

        // R1: compare register reset value 0 matches timer 0, flag-only mode
        mode = 4'b1010; tmr_val = 16'h0000; cyc("R1 reset cmp");
        check("R1 zero match flag", flag_out, 1);
        flag_clr = 1'b1; tmr_val = 16'h0001; cyc("R5 clear");

        // R1: write applies next cycle; single-bit misses never match
        write_cmp(16'hA5C3);
        for (int b = 0; b < W; b++) begin
            tmr_val = 16'hA5C3 ^ (16'h1 << b);
            cyc("R1 bit miss");
        end
        check("R1 no false match", flag_out, 0);
        tmr_val = 16'hA5C3; cyc("R4 match");
        check("R4 pin unchanged", pin_out, 0);
        check("R4 flag set", flag_out, 1);

        // R2 / R7: enter set mode (preset 0) then match drives 1
        tmr_val = 16'h0000; flag_clr = 1'b1; cyc("R5 clear");
        write_cmp(16'h1234);
        mode = 4'b1000; tmr_val = 16'h1233; cyc("R7 set entry");
        check("R7 preset low", pin_out, 0);
        tmr_val = 16'h1234;
        #2 check("R12 no early change", pin_out, 0);
        cyc("R2 match");
        check("R2 pin high", pin_out, 1);
        // R6: hold the match, clear the flag, no re-set
        flag_clr = 1'b1; cyc("R6 held");
        cyc("R6 held");
        cyc("R6 held");
        check("R6 flag stays clear", flag_out, 0);
        tmr_val = 16'h1235; cyc("R6 gap");
        tmr_val = 16'h1234; cyc("R6 new episode");
        check("R6 second episode flag", flag_out, 1);

        // R3 / R7: enter clear mode (preset 1) then match drives 0
        tmr_val = 16'h0000; mode = 4'b1001; cyc("R7 clr entry");
        check("R7 preset high", pin_out, 1);
        tmr_val = 16'h1234; cyc("R3 match");
        check("R3 pin low", pin_out, 0);

        // R7: re-enter set mode while pin is 1 at a non-match: preset to 0
        tmr_val = 16'h0000; mode = 4'b0000; cyc("R10 idle");
        mode = 4'b1001; cyc("R7 clr entry again");
        mode = 4'b1000; cyc("R7 set entry from high");
        check("R7 preset overrides", pin_out, 0);
        // R7: entry coinciding with match, match wins
        mode = 4'b1001; tmr_val = 16'h1234; cyc("R7 entry+match");
        check("R7 match wins", pin_out, 0);

        // R5: match and clear in the same cycle
        tmr_val = 16'h0000; mode = 4'b1010; flag_clr = 1'b1; cyc("R5 clear");
        tmr_val = 16'h1234; flag_clr = 1'b1; cyc("R5 set wins");
        check("R5 set beats clear", flag_out, 1);

        // R8 / R9: trigger mode with converter disabled then enabled
        tmr_val = 16'h0000; mode = 4'b1011; conv_en = 1'b0; cyc("R8 idle");
        tmr_val = 16'h1234; cyc("R8 trig");
        check("R8 pulse", tmr_rst, 1);
        check("R9 no conv when off", conv_start, 0);
        cyc("R8 held");
        check("R8 pulse single", tmr_rst, 0);
        tmr_val = 16'h0000; conv_en = 1'b1; cyc("R9 gap");
        tmr_val = 16'h1234; cyc("R9 conv");
        check("R9 conv pulse", conv_start, 1);
        tmr_val = 16'h0000; cyc("R9 after");
        check("R9 conv single", conv_start, 0);

        // R10 (and R2..R5, R8 for valid codes): sweep every mode code
        for (int c = 0; c < 16; c++) begin
            tmr_val = 16'hFFFF; mode = 4'(c); flag_clr = 1'b1; cyc("R10 prep");
            tmr_val = 16'h1234; cyc((c >= 8 && c <= 11) ? "R5 sweep" : "R10 sweep");
            if (c < 8 || c > 11) check("R10 no flag", flag_out, 0);
            tmr_val = 16'h0000; cyc("R10 leave");
        end

        // R11: reset in the middle of activity
        mode = 4'b1000; tmr_val = 16'h1234; cyc("R2 before reset");
        do_reset();

        done = 1;
        summary();
    end
endmodule